// File: doc/BRIEF.md
# Frame-Synchronised PCM Serial Transmitter

This block sends one 8-bit companded voice code per frame onto a shared serial PCM line. A parallel producer hands it a code word with a one-cycle valid strobe; the block stores that word and, when the frame sync rises, shifts it out most significant bit first, one bit per bit-clock period. The bit clock and the frame sync come from outside and are sampled by a faster system clock through synchroniser chains, so the clock can be continuous or a burst of nine or more pulses per frame.

The line is driven only during the eight bit slots of the frame. Outside them the enable output is low and the data output rests at 0, so several such transmitters can share one wired line, each with its own sync. A mode input selects A-law formatting, in which alternate bits of the code are inverted before sending, or mu-law formatting, in which the code goes out as written. If the frame sync stops toggling, a timer declares the transmit path powered down and releases the line until the next sync edge.

Top module: `pcm_tx_port`

## Requirements
- R1: While the line is enabled, the code goes out MSB first, each bit-clock rising edge after the launch moves to the next lower bit, and the data output does not change between those edges.
- R2: A rising edge of the frame sync loads the formatted word and enables the line with its MSB, whether or not a bit-clock rising edge arrives with it; a bit-clock edge in the same system cycle as the sync edge is not counted. Outputs follow an input edge after three system-clock cycles.
- R3: The line stays enabled for eight bit slots only: the bit-clock rising edge that would start a ninth slot releases it (enable 0, data 0), and it stays released across any pause of the bit clock until the next sync edge.
- R4: With the A-law mode input at 1, the sent word is the stored code XOR 8'h55 (code bits 6, 4, 2 and 0 inverted, bit 7 being the first bit sent); with it at 0 the stored code is sent unchanged. The mode is taken at the sync edge.
- R5: A word is stored in the cycle its valid strobe is 1. A frame sends the last word stored before its sync edge; a word stored during a frame waits for the next frame, and with no new word the previous one is sent again.
- R6: If no sync rising edge is seen for STUCK_US microseconds of system-clock time (SYS_KHZ kHz), the power-down output goes to 1 and the line is released, abandoning any slot in progress; the next sync rising edge clears power-down and launches a frame. The line is never enabled while power-down is 1.
- R7: After reset the line is released with data 0, power-down is 1 and the stored code is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, continuous or burst |
| fsync_i | input | 1 | Frame sync, phase-aligned to the bit clock |
| alaw_mode_i | input | 1 | 1: A-law alternate-bit inversion, 0: code sent as is |
| code_i | input | 8 | Companded code word from the producer |
| code_vld_i | input | 1 | Strobe that stores code_i |
| pcm_data_o | output | 1 | Serial data, 0 while released |
| pcm_oe_o | output | 1 | Line drive enable, high only in the eight slots |
| pwrdn_o | output | 1 | Transmit path powered down (sync stuck) |

## Verification
The assertions check on every cycle that a sync edge enables the line, that the data holds between bit-clock edges and steps to the next bit on each one, that the eighth advance releases the line, that a strobe stores its word, and that the stuck timer and the sync edge set and clear power-down while the enable never overlaps it. Only the bench scenarios can show the whole bit sequence of a frame against a word computed from the code and mode, the alternate-bit inversion, which word a frame picks when a new one arrives mid-frame or none at all, the line staying released through a burst-clock pause, the launch of the MSB by a sync that rises between clock edges, and the timing of the stuck-sync window.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

  localparam int unsigned CODE_W = 8;

  typedef logic [CODE_W-1:0] pcm_code_t;

  // alternate-bit inversion pattern, counting bit 7 (sent first) as bit one
  localparam pcm_code_t ALT_INV_MASK = 8'h55;

  function automatic pcm_code_t fmt_code(input pcm_code_t raw, input logic alaw);
    return alaw ? (raw ^ ALT_INV_MASK) : raw;
  endfunction

endpackage

// File: rtl/pcm_tx_edge.sv
module pcm_tx_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/pcm_tx_word.sv
module pcm_tx_word
  import pcm_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pcm_code_t code_i,
  input  logic      code_vld_i,
  output pcm_code_t held_o
);

  pcm_code_t held_q;
  pcm_code_t held_d;

  always_comb begin
    held_d = held_q;
    if (code_vld_i) begin
      held_d = code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else begin
      held_q <= held_d;
    end
  end

  assign held_o = held_q;

  AST_WORD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld_i |=> (held_o == $past(code_i))); // R5

endmodule

// File: rtl/pcm_tx_watch.sv
module pcm_tx_watch #(
  parameter int unsigned LIMIT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_rise_i,
  output logic stuck_hit_o,
  output logic pwrdn_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          pwrdn_q;
  logic          pwrdn_d;
  logic          at_limit;

  assign at_limit    = (cnt_q == LAST_CNT);
  assign stuck_hit_o = at_limit & ~sync_rise_i;

  always_comb begin
    cnt_d   = cnt_q;
    pwrdn_d = pwrdn_q;
    if (sync_rise_i) begin
      cnt_d   = '0;
      pwrdn_d = 1'b0;
    end else if (at_limit) begin
      pwrdn_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pwrdn_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      pwrdn_q <= pwrdn_d;
    end
  end

  assign pwrdn_o = pwrdn_q;

  AST_STUCK_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_hit_o |=> pwrdn_o); // R6

  AST_SYNC_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise_i |=> !pwrdn_o); // R6

endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift
  import pcm_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_rise_i,
  input  logic      bclk_rise_i,
  input  logic      stuck_i,
  input  pcm_code_t word_i,
  output logic      oe_o,
  output logic      data_o
);

  localparam int unsigned IW = $clog2(CODE_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(CODE_W - 1);

  logic            oe_q;
  logic            oe_d;
  logic [IW-1:0]   idx_q;
  logic [IW-1:0]   idx_d;
  pcm_code_t       sh_q;
  pcm_code_t       sh_d;

  always_comb begin
    oe_d  = oe_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    if (sync_rise_i) begin
      oe_d  = 1'b1;
      idx_d = '0;
      sh_d  = word_i;
    end else if (stuck_i) begin
      oe_d  = 1'b0;
      idx_d = '0;
    end else if (oe_q && bclk_rise_i) begin
      if (idx_q == LAST_IDX) begin
        oe_d  = 1'b0;
        idx_d = '0;
      end else begin
        idx_d = idx_q + 1'b1;
        sh_d  = {sh_q[CODE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      idx_q <= '0;
      sh_q  <= '0;
    end else begin
      oe_q  <= oe_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
    end
  end

  assign oe_o   = oe_q;
  assign data_o = oe_q & sh_q[CODE_W-1];

  AST_SYNC_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rise_i |=> oe_o); // R2

  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && !sync_rise_i && !bclk_rise_i && !stuck_i) |=> $stable(data_o)); // R1

  AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && bclk_rise_i && !sync_rise_i && !stuck_i && (idx_q != LAST_IDX))
      |=> (oe_o && (data_o == $past(sh_q[CODE_W-2])))); // R1

  AST_SLOT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && bclk_rise_i && !sync_rise_i && (idx_q == LAST_IDX)) |=> !oe_o); // R3

endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int unsigned SYS_KHZ     = 16384,
  parameter int unsigned STUCK_US    = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              alaw_mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_vld_i,
  output logic              pcm_data_o,
  output logic              pcm_oe_o,
  output logic              pwrdn_o
);

  localparam int unsigned STUCK_CYC = (SYS_KHZ * STUCK_US) / 1000;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic      bclk_rise;
  logic      sync_rise;
  logic      stuck_hit;
  pcm_code_t held_word;
  pcm_code_t load_word;

  pcm_tx_edge #(.STAGES(SYNC_STAGES)) u_bclk_edge (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (bclk_i),
    .rise_o  (bclk_rise)
  );

  pcm_tx_edge #(.STAGES(SYNC_STAGES)) u_sync_edge (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (fsync_i),
    .rise_o  (sync_rise)
  );

  pcm_tx_word u_word (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .code_i     (code_i),
    .code_vld_i (code_vld_i),
    .held_o     (held_word)
  );

  assign load_word = fmt_code(held_word, alaw_mode_i);

  pcm_tx_watch #(.LIMIT(STUCK_CYC)) u_watch (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .sync_rise_i (sync_rise),
    .stuck_hit_o (stuck_hit),
    .pwrdn_o     (pwrdn_o)
  );

  pcm_tx_shift u_shift (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .sync_rise_i (sync_rise),
    .bclk_rise_i (bclk_rise),
    .stuck_i     (stuck_hit),
    .word_i      (load_word),
    .oe_o        (pcm_oe_o),
    .data_o      (pcm_data_o)
  );

  AST_NO_DRIVE_IN_PWRDN: assert property (@(posedge clk) disable iff (!rst_sync_q)
    pcm_oe_o |-> !pwrdn_o); // R6

endmodule

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned SYS_KHZ    = 16384;
  localparam int unsigned STUCK_US   = 2000;
  localparam int unsigned STUCK_CYC  = (SYS_KHZ * STUCK_US) / 1000;
  localparam int unsigned HALF_BCLK  = 6;
  localparam int unsigned WDOG_LIMIT = 150000;

  logic       clk;
  logic       rst_n;
  logic       bclk_i;
  logic       fsync_i;
  logic       alaw_mode_i;
  logic [7:0] code_i;
  logic       code_vld_i;
  logic       pcm_data_o;
  logic       pcm_oe_o;
  logic       pwrdn_o;

  int n_tests;
  int n_fail;
  int wdog;

  pcm_tx_port #(
    .SYS_KHZ     (SYS_KHZ),
    .STUCK_US    (STUCK_US),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_i      (bclk_i),
    .fsync_i     (fsync_i),
    .alaw_mode_i (alaw_mode_i),
    .code_i      (code_i),
    .code_vld_i  (code_vld_i),
    .pcm_data_o  (pcm_data_o),
    .pcm_oe_o    (pcm_oe_o),
    .pwrdn_o     (pwrdn_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial wdog = 0;
  always @(posedge clk) begin
    wdog <= wdog + 1;
    if (wdog == WDOG_LIMIT) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", wdog, WDOG_LIMIT);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_word(input logic [7:0] raw, input logic alaw);
    return alaw ? (raw ^ 8'h55) : raw;
  endfunction

  // one bit-clock period starting at a falling system-clock edge; samples in the low phase
  task automatic clk_period(output logic oe_s, output logic d_s);
    bclk_i = 1'b1;
    repeat (HALF_BCLK) @(negedge clk);
    bclk_i = 1'b0;
    repeat (3) @(negedge clk);
    oe_s = pcm_oe_o;
    d_s  = pcm_data_o;
    repeat (HALF_BCLK - 3) @(negedge clk);
  endtask

  task automatic put_word(input logic [7:0] w);
    code_i     = w;
    code_vld_i = 1'b1;
    @(negedge clk);
    code_vld_i = 1'b0;
  endtask

  // early=1: sync rises in the low phase, before the first bit-clock edge
  task automatic run_frame(input logic [7:0] raw, input int nper, input bit early,
                           input int wr_at, input logic [7:0] wr_word, input string tag);
    logic [7:0] exp;
    logic oe_s;
    logic d_s;
    exp = expect_word(raw, alaw_mode_i);
    if (early) begin
      fsync_i = 1'b1;
      repeat (4) @(negedge clk);
      chk(pcm_oe_o == 1'b1 && pcm_data_o == exp[7], "R2 launch on sync edge",
          {6'd0, pcm_oe_o, pcm_data_o}, {7'd1, exp[7]});
      repeat (HALF_BCLK - 4) @(negedge clk);
    end
    for (int k = 0; k < nper; k++) begin
      if (k == wr_at) put_word(wr_word);
      if (!early && k == 0) fsync_i = 1'b1;
      if (k == 1) fsync_i = 1'b0;
      clk_period(oe_s, d_s);
      begin
        int pos;
        pos = early ? k + 1 : k;
        if (pos < 8) begin
          chk(oe_s == 1'b1 && d_s == exp[7-pos], {"R1 ", tag},
              {6'd0, oe_s, d_s}, {7'd1, exp[7-pos]});
        end else begin
          chk(oe_s == 1'b0 && d_s == 1'b0, {"R3 release ", tag},
              {6'd0, oe_s, d_s}, 8'd0);
        end
      end
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(pcm_oe_o == 1'b0 && pcm_data_o == 1'b0 && pwrdn_o == 1'b1, "R7 in reset",
        {5'd0, pcm_oe_o, pcm_data_o, pwrdn_o}, 8'd1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pcm_oe_o == 1'b0 && pwrdn_o == 1'b1, "R7 after release",
        {6'd0, pcm_oe_o, pwrdn_o}, 8'd1);
    // no word ever stored: the frame carries 8'h00
    alaw_mode_i = 1'b0;
    run_frame(8'h00, 10, 1'b0, -1, 8'h00, "R7 reset word");
    chk(pwrdn_o == 1'b0, "R6 wake on sync", {7'd0, pwrdn_o}, 8'd0);
  endtask

  task automatic t_mulaw;
    alaw_mode_i = 1'b0;
    put_word(8'hA5);
    run_frame(8'hA5, 10, 1'b0, -1, 8'h00, "R4 mu-law A5");
    put_word(8'h3C);
    run_frame(8'h3C, 10, 1'b0, -1, 8'h00, "R4 mu-law 3C");
  endtask

  task automatic t_alaw;
    alaw_mode_i = 1'b1;
    put_word(8'h80);
    run_frame(8'h80, 10, 1'b0, -1, 8'h00, "R4 A-law 80");
    put_word(8'hFF);
    run_frame(8'hFF, 10, 1'b0, -1, 8'h00, "R4 A-law FF");
  endtask

  task automatic t_repeat_and_midframe;
    alaw_mode_i = 1'b0;
    put_word(8'h5A);
    run_frame(8'h5A, 10, 1'b0, -1, 8'h00, "R5 first");
    run_frame(8'h5A, 10, 1'b0, -1, 8'h00, "R5 repeat");
    run_frame(8'h5A, 10, 1'b0, 3, 8'hC3, "R5 mid-frame write waits");
    run_frame(8'hC3, 10, 1'b0, -1, 8'h00, "R5 next frame takes new word");
  endtask

  task automatic t_burst;
    alaw_mode_i = 1'b1;
    put_word(8'h17);
    run_frame(8'h17, 9, 1'b0, -1, 8'h00, "R3 burst 1");
    repeat (40) begin
      @(negedge clk);
      if (pcm_oe_o !== 1'b0) break;
    end
    chk(pcm_oe_o == 1'b0 && pcm_data_o == 1'b0, "R3 released in clock gap",
        {6'd0, pcm_oe_o, pcm_data_o}, 8'd0);
    put_word(8'hE8);
    run_frame(8'hE8, 9, 1'b0, -1, 8'h00, "R3 burst 2");
  endtask

  task automatic t_early_sync;
    alaw_mode_i = 1'b0;
    put_word(8'hB2);
    run_frame(8'hB2, 9, 1'b1, -1, 8'h00, "R2 early sync");
  endtask

  task automatic t_stuck;
    alaw_mode_i = 1'b0;
    put_word(8'h81);
    // sync rises and then stays high with no bit clock: the slot hangs until the timer
    fsync_i = 1'b1;
    repeat (8) @(negedge clk);
    chk(pcm_oe_o == 1'b1 && pcm_data_o == 1'b1, "R2 launch without clock",
        {6'd0, pcm_oe_o, pcm_data_o}, 8'd3);
    repeat (STUCK_CYC - 60) @(negedge clk);
    chk(pwrdn_o == 1'b0 && pcm_oe_o == 1'b1, "R6 not yet stuck",
        {6'd0, pwrdn_o, pcm_oe_o}, 8'd1);
    repeat (100) @(negedge clk);
    chk(pwrdn_o == 1'b1 && pcm_oe_o == 1'b0 && pcm_data_o == 1'b0, "R6 stuck high",
        {5'd0, pwrdn_o, pcm_oe_o, pcm_data_o}, 8'd4);
    fsync_i = 1'b0;
    repeat (20) @(negedge clk);
    chk(pwrdn_o == 1'b1 && pcm_oe_o == 1'b0, "R6 falling edge does not wake",
        {6'd0, pwrdn_o, pcm_oe_o}, 8'd2);
    run_frame(8'h81, 10, 1'b0, -1, 8'h00, "R6 resume");
    chk(pwrdn_o == 1'b0, "R6 cleared after resume", {7'd0, pwrdn_o}, 8'd0);
  endtask

  initial begin
    n_tests     = 0;
    n_fail      = 0;
    rst_n       = 1'b0;
    bclk_i      = 1'b0;
    fsync_i     = 1'b0;
    alaw_mode_i = 1'b0;
    code_i      = 8'h00;
    code_vld_i  = 1'b0;
    @(negedge clk);
    t_reset();
    t_mulaw();
    t_alaw();
    t_repeat_and_midframe();
    t_burst();
    t_early_sync();
    t_stuck();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule